// File: doc/BRIEF.md
# Manchester Receive Decoder with Carrier Sense

This block turns an oversampled Manchester line into NRZ receive data, a recovered receive clock and a carrier-sense flag for a 10 Mbit/s controller. The line is sampled once per clock of a fast sampling clock, by default sixteen samples per bit, which is 160 MHz at the nominal rate. A digital counter tracks the bit phase: each accepted mid-cell transition restarts it, and it stands in for an analog phase-locked loop.

Carrier sense rises on the first falling transition seen while idle. That transition is taken as the first mid-cell edge. The decoder locks once it has seen a run of alternating preamble transitions. From then on every mid-cell transition produces one data bit. When mid-cell transitions stop, carrier sense drops in well under one and a half bit times. The receive clock then keeps running for exactly five more bit times, so that the controller can finish its last bytes. A loopback select makes the decoder listen to the local encoder's stream in place of the line.

Top module: `manchester_rx`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `crs`, `rxc` and `rxd` are 0.
- R2: With carrier off, a falling transition of the selected input (a 1 sample followed by a 0 sample) raises `crs` two clocks after the 0 sample is presented. A rising transition while idle has no effect.
- R3: With carrier on, a transition counts as a mid-cell transition only if it arrives SPB-WIN to SPB+WIN samples (13 to 19 by default) after the previous accepted one. Any other transition, such as a cell-boundary edge or a short glitch, changes no output.
- R4: The decoder locks after LOCK_EDGES (4) further accepted transitions, each opposite in direction to the one before, counted from the carrier-start edge. A transition in the same direction as the one before restarts the count. Before lock, `rxd` does not change and `rxc` stays low.
- R5: Once locked, every accepted mid-cell transition updates `rxd` one clock after it reaches the edge detector. A rising transition gives 1 and a falling transition gives 0.
- R6: While the receive clock runs, `rxc` is low for the first SPB/2 samples after the last resynchronisation and high for the next SPB/2. It free-runs at the bit period between resynchronisations, so `rxd` changes only while `rxc` is low.
- R7: With carrier on, `crs` falls when SPB+WIN samples pass with no accepted transition. A transition arriving on that last sample is still accepted.
- R8: If the decoder was locked when carrier dropped, `rxc` runs for exactly TAIL_BITS×SPB clocks after `crs` falls (five rising edges by default), then stays low.
- R9: With `lpbk` = 1 the decoder uses `lb_bit` and ignores `line_bit`. With `lpbk` = 0 it uses `line_bit`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, SPB samples per bit |
| rst | input | 1 | Synchronous active-high reset |
| line_bit | input | 1 | Sampled line level from the receiver |
| lb_bit | input | 1 | Local encoder output used in loopback |
| lpbk | input | 1 | 1 selects `lb_bit` as the decoder input |
| rxd | output | 1 | Recovered NRZ data, stable at `rxc` rising |
| rxc | output | 1 | Recovered receive clock |
| crs | output | 1 | Carrier sense |

## Verification
Two functions can act in the same cycle, and the bench provokes both cases.

- **Timeout against a late edge.** The carrier timeout can coincide with the latest mid-cell transition the window still accepts. The bench stretches one half-cell by three samples, so that the edge lands on the very sample where the timeout would fire, and expects decoding to continue. It stretches another by four samples and expects carrier to drop mid-frame.
- **New frame during the tail.** The receive-clock tail can still be running when a new carrier starts. The bench sends back-to-back frames with a short idle gap.

A behavioural reference model predicts `crs`, `rxc` and `rxd` on every clock. The bench judges each cycle against it, and also checks the decoded payload and the count of tail clocks.

// File: rtl/manrx_pkg.sv
package manrx_pkg;

    typedef enum logic {
        CARRIER_OFF = 1'b0,
        CARRIER_ON  = 1'b1
    } carrier_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    typedef struct packed {
        logic sync;
        logic drop_locked;
        logic locked;
    } track_t;

    function automatic logic in_window(input int unsigned c,
                                       input int unsigned lo,
                                       input int unsigned hi);
        return (c >= lo) && (c <= hi);
    endfunction

endpackage

// File: rtl/manrx_sampler.sv
module manrx_sampler
    import manrx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  line_bit,
    input  logic  lb_bit,
    input  logic  lpbk,
    output edge_t edges
);
    logic smp_now;
    logic smp_old;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_now <= 1'b0;
            smp_old <= 1'b0;
        end else begin
            smp_now <= lpbk ? lb_bit : line_bit;
            smp_old <= smp_now;
        end
    end

    assign edges.rise = smp_now & ~smp_old;
    assign edges.fall = ~smp_now & smp_old;
endmodule

// File: rtl/manrx_tracker.sv
module manrx_tracker
    import manrx_pkg::*;
#(
    parameter int SPB        = 16,
    parameter int WIN        = 3,
    parameter int LOCK_EDGES = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  edge_t  edges,
    output logic   carrier,
    output logic   rxd,
    output track_t trk
);
    localparam int WIN_LO = SPB - 1 - WIN;
    localparam int WIN_HI = SPB - 1 + WIN;
    localparam int CNT_W  = $clog2(WIN_HI + 1);
    localparam int PRE_W  = (LOCK_EDGES > 1) ? $clog2(LOCK_EDGES) : 1;

    carrier_e           state;
    logic [CNT_W-1:0]   since_mid;
    logic [PRE_W-1:0]   alt_run;
    logic               last_rise;
    logic               locked_q;
    logic               rxd_q;
    logic               any_edge;
    logic               mid_hit;
    logic               expire;

    always_comb begin
        any_edge = edges.rise | edges.fall;
        mid_hit  = (state == CARRIER_ON) && any_edge &&
                   in_window(32'(since_mid), WIN_LO, WIN_HI);
        expire   = (state == CARRIER_ON) && !mid_hit &&
                   (since_mid == CNT_W'(WIN_HI));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= CARRIER_OFF;
            since_mid <= '0;
            alt_run   <= '0;
            last_rise <= 1'b0;
            locked_q  <= 1'b0;
            rxd_q     <= 1'b0;
        end else begin
            unique case (state)
                CARRIER_OFF: begin
                    if (edges.fall) begin
                        state     <= CARRIER_ON;
                        since_mid <= '0;
                        alt_run   <= '0;
                        last_rise <= 1'b0;
                        locked_q  <= 1'b0;
                    end
                end
                CARRIER_ON: begin
                    if (mid_hit) begin
                        since_mid <= '0;
                        last_rise <= edges.rise;
                        if (locked_q) begin
                            rxd_q <= edges.rise;
                        end else if (edges.rise != last_rise) begin
                            if (alt_run == PRE_W'(LOCK_EDGES - 1))
                                locked_q <= 1'b1;
                            else
                                alt_run <= alt_run + 1'b1;
                        end else begin
                            alt_run <= '0;
                        end
                    end else if (expire) begin
                        state    <= CARRIER_OFF;
                        locked_q <= 1'b0;
                    end else begin
                        since_mid <= since_mid + 1'b1;
                    end
                end
                default: state <= CARRIER_OFF;
            endcase
        end
    end

    assign carrier         = (state == CARRIER_ON);
    assign rxd             = rxd_q;
    assign trk.sync        = mid_hit | ((state == CARRIER_OFF) & edges.fall);
    assign trk.drop_locked = expire & locked_q;
    assign trk.locked      = locked_q;
endmodule

// File: rtl/manrx_clkgen.sv
module manrx_clkgen
    import manrx_pkg::*;
#(
    parameter int SPB       = 16,
    parameter int TAIL_BITS = 5
) (
    input  logic   clk,
    input  logic   rst,
    input  track_t trk,
    output logic   rxc
);
    localparam int PH_W     = $clog2(SPB);
    localparam int TAIL_CYC = TAIL_BITS * SPB;
    localparam int TAIL_W   = $clog2(TAIL_CYC + 1);
    localparam bit PH_POW2  = ((1 << PH_W) == SPB);

    logic [PH_W-1:0]   bit_ph;
    logic [PH_W-1:0]   ph_next;
    logic [TAIL_W-1:0] tail_left;

    generate
        if (PH_POW2) begin : g_wrap_free
            assign ph_next = bit_ph + 1'b1;
        end else begin : g_wrap_cmp
            assign ph_next = (bit_ph == PH_W'(SPB - 1)) ? '0 : bit_ph + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_ph    <= '0;
            tail_left <= '0;
        end else begin
            bit_ph <= trk.sync ? '0 : ph_next;
            if (trk.drop_locked)
                tail_left <= TAIL_W'(TAIL_CYC);
            else if (tail_left != '0)
                tail_left <= tail_left - 1'b1;
        end
    end

    assign rxc = (trk.locked || (tail_left != '0)) && (bit_ph >= PH_W'(SPB / 2));
endmodule

// File: rtl/manchester_rx.sv
module manchester_rx
    import manrx_pkg::*;
#(
    parameter int SPB        = 16,
    parameter int WIN        = 3,
    parameter int LOCK_EDGES = 4,
    parameter int TAIL_BITS  = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic line_bit,
    input  logic lb_bit,
    input  logic lpbk,
    output logic rxd,
    output logic rxc,
    output logic crs
);
    edge_t  edges;
    track_t trk;

    manrx_sampler u_sampler (
        .clk      (clk),
        .rst      (rst),
        .line_bit (line_bit),
        .lb_bit   (lb_bit),
        .lpbk     (lpbk),
        .edges    (edges)
    );

    manrx_tracker #(
        .SPB        (SPB),
        .WIN        (WIN),
        .LOCK_EDGES (LOCK_EDGES)
    ) u_tracker (
        .clk     (clk),
        .rst     (rst),
        .edges   (edges),
        .carrier (crs),
        .rxd     (rxd),
        .trk     (trk)
    );

    manrx_clkgen #(
        .SPB       (SPB),
        .TAIL_BITS (TAIL_BITS)
    ) u_clkgen (
        .clk (clk),
        .rst (rst),
        .trk (trk),
        .rxc (rxc)
    );
endmodule

// File: rtl/manrx_checker.sv
module manrx_checker #(
    parameter int SPB       = 16,
    parameter int WIN       = 3,
    parameter int TAIL_BITS = 5
) (
    input logic clk,
    input logic rst,
    input logic line_bit,
    input logic lb_bit,
    input logic lpbk,
    input logic rxd,
    input logic rxc,
    input logic crs
);
    localparam int QW     = $clog2(4 * SPB);
    localparam int TAIL_C = TAIL_BITS * SPB;
    localparam int OW     = $clog2(TAIL_C + 2) + 1;

    logic          sel;
    logic          sel_prev;
    logic [QW-1:0] quiet;
    logic [OW-1:0] off_cnt;

    assign sel = lpbk ? lb_bit : line_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_prev <= 1'b0;
            quiet    <= '0;
            off_cnt  <= '0;
        end else begin
            sel_prev <= sel;
            if (sel != sel_prev)
                quiet <= '0;
            else if (quiet != '1)
                quiet <= quiet + 1'b1;
            if (crs)
                off_cnt <= '0;
            else if (off_cnt != '1)
                off_cnt <= off_cnt + 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!crs && !rxc && !rxd));

    assert_carrier_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(crs) |-> (!$past(sel, 2) && $past(sel, 3)));

    assert_data_in_carrier_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(rxd) |-> $past(crs));

    assert_data_moves_low_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(rxd) |-> !rxc);

    assert_carrier_timeout_R7: assert property (@(posedge clk) disable iff (rst)
        crs |-> (32'(quiet) <= SPB + WIN + 1));

    assert_tail_length_R8: assert property (@(posedge clk) disable iff (rst)
        (rxc && !crs) |-> (32'(off_cnt) < TAIL_C));
endmodule

bind manchester_rx manrx_checker #(
    .SPB       (SPB),
    .WIN       (WIN),
    .TAIL_BITS (TAIL_BITS)
) u_manrx_checker (
    .clk      (clk),
    .rst      (rst),
    .line_bit (line_bit),
    .lb_bit   (lb_bit),
    .lpbk     (lpbk),
    .rxd      (rxd),
    .rxc      (rxc),
    .crs      (crs)
);

// File: tb/test_manchester_rx.sv
module test_manchester_rx;
    localparam int SPB   = 16;
    localparam int WIN   = 3;
    localparam int LOCKN = 4;
    localparam int TAILB = 5;
    localparam int HALF  = SPB / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_bit = 1'b0;
    logic lb_bit = 1'b0;
    logic lpbk = 1'b0;
    logic rxd, rxc, crs;

    always #2 clk = ~clk;

    manchester_rx #(.SPB(SPB), .WIN(WIN), .LOCK_EDGES(LOCKN), .TAIL_BITS(TAILB))
    i_manchester_rx (
        .clk(clk), .rst(rst), .line_bit(line_bit), .lb_bit(lb_bit),
        .lpbk(lpbk), .rxd(rxd), .rxc(rxc), .crs(crs)
    );

    int vectors = 0;
    int miscomp = 0;
    bit cmp_en = 1'b0;

    // behavioural reference model
    int ms0, ms1, mcrs, mcnt, mpol, mpre, mlock, mrxd, mtail, mph;
    int mef, mer, msync, mdrop;

    always @(posedge clk) begin
        if (rst) begin
            ms0 = 0; ms1 = 0; mcrs = 0; mcnt = 0; mpol = 0; mpre = 0;
            mlock = 0; mrxd = 0; mtail = 0; mph = 0;
        end else begin
            mef = (ms1 == 1 && ms0 == 0) ? 1 : 0;
            mer = (ms0 == 1 && ms1 == 0) ? 1 : 0;
            msync = 0; mdrop = 0;
            if (mcrs == 0) begin
                if (mef == 1) begin
                    mcrs = 1; mcnt = 0; mpol = 0; mpre = 0; mlock = 0; msync = 1;
                end
            end else if ((mef == 1 || mer == 1) && mcnt >= SPB-1-WIN && mcnt <= SPB-1+WIN) begin
                msync = 1; mcnt = 0;
                if (mlock == 1) mrxd = mer;
                else if (mer != mpol) begin
                    if (mpre == LOCKN-1) mlock = 1; else mpre++;
                end else mpre = 0;
                mpol = mer;
            end else if (mcnt == SPB-1+WIN) begin
                mdrop = mlock; mcrs = 0; mlock = 0;
            end else begin
                mcnt++;
            end
            if (mdrop == 1) mtail = TAILB * SPB;
            else if (mtail > 0) mtail--;
            mph = (msync == 1) ? 0 : (mph + 1) % SPB;
            ms1 = ms0;
            ms0 = lpbk ? int'(lb_bit) : int'(line_bit);
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            int exp_rxc;
            exp_rxc = ((mlock == 1 || mtail > 0) && mph >= HALF) ? 1 : 0;
            vectors += 3;
            if (int'(crs) !== mcrs) begin
                miscomp++;
                $display("FAIL R7 crs actual=%0d expected=%0d t=%0t", crs, mcrs, $time);
            end
            if (int'(rxc) !== exp_rxc) begin
                miscomp++;
                $display("FAIL R6 rxc actual=%0d expected=%0d t=%0t", rxc, exp_rxc, $time);
            end
            if (int'(rxd) !== mrxd) begin
                miscomp++;
                $display("FAIL R5 rxd actual=%0d expected=%0d t=%0t", rxd, mrxd, $time);
            end
        end
    end

    // output monitor
    bit mon_en = 1'b0;
    bit prev_rxc = 1'b0;
    bit cap[$];
    int tail_rises = 0;
    int any_rises = 0;

    always @(negedge clk) begin
        if (mon_en && rxc && !prev_rxc) begin
            any_rises++;
            if (crs) cap.push_back(rxd);
            else tail_rises++;
        end
        prev_rxc = rxc;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscomp++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_frame(input bit bits[$], input int lock_idx, input bit use_lb,
                             input bit jit, input int stretch_at, input int stretch_amt,
                             input int glitch_at, input int idle_len, input bit do_check,
                             input string tag);
        bit smp[$];
        int bad;
        for (int i = 0; i < bits.size(); i++) begin
            int j;
            int h1;
            j  = jit ? int'($urandom_range(0, 2)) - 1 : 0;
            h1 = HALF + j + ((i == stretch_at) ? stretch_amt : 0);
            for (int k = 0; k < h1; k++)
                smp.push_back((i == glitch_at && k == 1) ? bits[i] : ~bits[i]);
            for (int k = 0; k < HALF - j; k++)
                smp.push_back(bits[i]);
        end
        for (int k = 0; k < idle_len; k++) smp.push_back(1'b0);
        cap.delete();
        tail_rises = 0;
        mon_en = 1'b1;
        foreach (smp[n]) begin
            @(negedge clk);
            lpbk = use_lb;
            if (use_lb) begin
                lb_bit   = smp[n];
                line_bit = 1'($urandom % 2);
            end else begin
                line_bit = smp[n];
                lb_bit   = 1'($urandom % 2);
            end
        end
        @(negedge clk);
        mon_en = 1'b0;
        if (do_check) begin
            chk(cap.size() == bits.size() - lock_idx, tag, cap.size(), bits.size() - lock_idx);
            bad = 0;
            for (int k = 1; k < cap.size() && lock_idx + k < bits.size(); k++)
                if (cap[k] != bits[lock_idx + k]) bad++;
            chk(bad == 0, tag, bad, 0);
            chk(tail_rises == TAILB, "R8", tail_rises, TAILB);
        end
    endtask

    function automatic void make_bits(ref bit q[$], input bit broken_pre, input int n_pay);
        q.delete();
        if (broken_pre) begin
            q.push_back(1'b1); q.push_back(1'b0); q.push_back(1'b0);
            for (int i = 0; i < 6; i++) q.push_back(1'(~i[0]));
        end else begin
            for (int i = 0; i < 8; i++) q.push_back(1'(~i[0]));
        end
        for (int i = 0; i < n_pay; i++) q.push_back(1'($urandom % 2));
    endfunction

    initial begin
        #(4 * 150000);
        miscomp++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

    initial begin
        bit bits[$];
        int n;
        int crs_seen;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        cmp_en = 1'b1;
        @(negedge clk);
        chk(!crs && !rxc && !rxd, "R1", {crs, rxc, rxd}, 0);

        // R2: isolated falling transition starts carrier; R7: timeout; R4: no lock
        any_rises = 0;
        mon_en = 1'b1;
        repeat (3) begin @(negedge clk); line_bit = 1'b1; end
        chk(!crs, "R2", crs, 0);
        @(negedge clk); line_bit = 1'b0;
        @(negedge clk);
        chk(!crs, "R2", crs, 0);
        @(negedge clk);
        chk(crs, "R2", crs, 1);
        n = 0;
        while (crs && n < 100) begin n++; @(negedge clk); end
        chk(n == SPB + WIN, "R7", n, SPB + WIN);
        repeat (40) @(negedge clk);
        mon_en = 1'b0;
        chk(any_rises == 0, "R4", any_rises, 0);

        // plain frame
        make_bits(bits, 1'b0, 24);
        run_frame(bits, 5, 1'b0, 1'b0, -1, 0, -1, 150, 1'b1, "R5");
        // jittered frame
        make_bits(bits, 1'b0, 24);
        run_frame(bits, 5, 1'b0, 1'b1, -1, 0, -1, 150, 1'b1, "R5");
        // broken preamble delays lock by one bit
        make_bits(bits, 1'b1, 20);
        run_frame(bits, 6, 1'b0, 1'b0, -1, 0, -1, 150, 1'b1, "R4");
        // latest accepted edge plus an out-of-window glitch
        make_bits(bits, 1'b0, 24);
        run_frame(bits, 5, 1'b0, 1'b0, 14, 3, 20, 150, 1'b1, "R3");
        // loopback frame with line noise
        make_bits(bits, 1'b0, 24);
        run_frame(bits, 5, 1'b1, 1'b1, -1, 0, -1, 150, 1'b1, "R9");

        // loopback idle: line toggling must not raise carrier
        crs_seen = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            lpbk = 1'b1; lb_bit = 1'b0; line_bit = 1'(i / 4 % 2);
            if (crs) crs_seen++;
        end
        chk(crs_seen == 0, "R9", crs_seen, 0);
        @(negedge clk); lpbk = 1'b0; line_bit = 1'b0;
        repeat (10) @(negedge clk);

        // one-sample-too-late edge: carrier drops mid-frame
        make_bits(bits, 1'b0, 24);
        run_frame(bits, 5, 1'b0, 1'b0, 15, 4, -1, 150, 1'b0, "R7");
        // back-to-back frames: new carrier while the tail still runs
        make_bits(bits, 1'b0, 16);
        run_frame(bits, 5, 1'b0, 1'b1, -1, 0, -1, 40, 1'b0, "R8");
        make_bits(bits, 1'b0, 16);
        run_frame(bits, 5, 1'b0, 1'b1, -1, 0, -1, 150, 1'b0, "R8");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end
endmodule